// File: doc/BRIEF.md
# Arm Command Dispatch Sequencer

This block sits on the master side of a converter made of six arm controllers. Once per sampling period it emits a one-cycle synchronization pulse that all arm controllers use to align their carriers. It then walks a fixed schedule of transactions through an abstract serial-bus transaction port: first a 16-bit command word to each arm controller, then a single read of one arm's total voltage. The arm that is read rotates by one every period, so a full set of six arm voltages is gathered every six periods. The physical bus sits outside the block. A bus controller receives a start pulse, an address, a read flag and write data, and it answers with either a done pulse carrying read data or a NACK pulse.

Each command word packs a 12-bit voltage reference together with the arm current sign and two drive-control bits. A global stop condition latches when any of four events occurs: an explicit stop command, the fault input, an arm controller that answers with NACK, or an arm controller that gives no answer within a timeout. From then on every word carries the halt encoding. The latch is released only by a start command given while the fault input is low. The schedule is given one sampling period to complete. If the next period begins before the schedule has finished, an overrun pulse is raised, the unfinished remainder is dropped, and the new period's schedule starts.

Top module: `arm_dispatch_top`

## Requirements
- R1: Every write carries a command word whose bits [11:0] hold that arm's reference, bit 12 holds its current sign, bit 13 (drive enable) equals the inverse of the stop state, bit 14 (halt) equals the stop state, and bit 15 is 0. The stop state is the one present in the cycle the write is issued.
- R2: In every period the block issues writes (txn_read = 0) to addresses 0, 1, 2, 3, 4 and 5, in that order, followed by exactly one read (txn_read = 1).
- R3: The read in the n-th period after reset (counting from 0) goes to address n mod 6. Data returned with txn_done appears on that arm's 16-bit slice of arm_volt, where arm i occupies bits [16i+15:16i]. A read answered with NACK leaves the slice unchanged.
- R4: sync_pulse is high for exactly one cycle every PERIOD_CYCLES cycles. The first pulse comes PERIOD_CYCLES-1 cycles after reset is released, and the first transaction of a period starts in the cycle after its pulse.
- R5: txn_start is a single-cycle pulse. The next transaction is not started until the current one has received txn_done, txn_nack or a timeout.
- R6: A NACK on any transaction sets the stop state in the following cycle. Every later write in the same period carries the halt encoding, and the schedule continues.
- R7: A transaction that receives neither done nor NACK within TIMEOUT_CYCLES cycles is treated exactly like a NACK.
- R8: A high fault_in or stop_cmd sets stop_out in the following cycle.
- R9: stop_out stays set until start_cmd is sampled high while fault_in is low and no stop cause is present. It clears in the following cycle. A start_cmd given while fault_in is high has no effect.
- R10: If a period's schedule has not finished when the next sync_pulse arrives, overrun is high in that cycle and the next transaction is the write to address 0. overrun never pulses when the schedule completes in time.
- R11: After reset, stop_out is 1, arm_volt is all zeros, and txn_start, sync_pulse and overrun are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_ref | input | NUM_ARMS*12 | Voltage reference per arm, arm i at [12i+11:12i] |
| arm_sign | input | NUM_ARMS | Arm current sign per arm |
| start_cmd | input | 1 | Request to release the stop state |
| stop_cmd | input | 1 | Request to set the stop state |
| fault_in | input | 1 | Master-detected fault, sets the stop state |
| txn_start | output | 1 | One-cycle request to begin a bus transaction |
| txn_addr | output | $clog2(NUM_ARMS) | Target arm controller address |
| txn_read | output | 1 | 1 for a read, 0 for a write |
| txn_wdata | output | 16 | Command word for writes, zero for reads |
| txn_rdata | input | 16 | Read data, valid with txn_done |
| txn_done | input | 1 | Transaction finished successfully |
| txn_nack | input | 1 | Transaction refused by the addressed arm controller |
| arm_volt | output | NUM_ARMS*16 | Last voltage received from each arm |
| sync_pulse | output | 1 | Period start and carrier-alignment pulse |
| overrun | output | 1 | Period ended before its schedule completed |
| stop_out | output | 1 | Global stop state |

## Verification
In most periods the references, signs, returned voltages and bus latencies are random, so that the packing of each field, the write order and the rotating read target can each be told apart from one another. Directed periods place a NACK on arm 2 and a silent arm 4. Because only the words issued after the failure must change encoding, these periods separate a latch that acts at once from one that waits for the next period. A bus latency too long for the period exposes overrun and the restart at address 0. Start commands given with the fault input high or low separate a gated release from an unconditional one.

// File: rtl/arm_dispatch_pkg.sv
package arm_dispatch_pkg;

    localparam int REF_W  = 12;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

    // Bit order of the outgoing command word, MSB first.
    typedef struct packed {
        logic             spare;
        logic             halt;
        logic             drive_en;
        logic             cur_sign;
        logic [REF_W-1:0] ref_val;
    } cmd_word_t;

    function automatic cmd_word_t pack_cmd(input logic [REF_W-1:0] r,
                                           input logic s,
                                           input logic stopped);
        cmd_word_t w;
        w.spare    = 1'b0;
        w.halt     = stopped;
        w.drive_en = ~stopped;
        w.cur_sign = s;
        w.ref_val  = r;
        return w;
    endfunction

endpackage

// File: rtl/period_timer.sv
module period_timer #(
    parameter int PERIOD_CYCLES = 25000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = $clog2(PERIOD_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == CNT_W'(PERIOD_CYCLES - 1));

    // R4: the period pulse is never wider than one cycle
    assert_tick_single_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/halt_latch.sv
module halt_latch (
    input  logic clk,
    input  logic rst,
    input  logic fault_in,
    input  logic stop_cmd,
    input  logic start_cmd,
    input  logic link_fail,
    output logic stop_q
);
    logic set_req;

    assign set_req = fault_in | stop_cmd | link_fail;

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q <= 1'b1;
        end else if (set_req) begin
            stop_q <= 1'b1;
        end else if (start_cmd) begin
            stop_q <= 1'b0;
        end
    end

    assert_fault_stops_R8: assert property (@(posedge clk) disable iff (rst)
        (fault_in || stop_cmd) |=> stop_q);

    assert_release_gated_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(stop_q) |-> ($past(start_cmd) && !$past(fault_in)));

endmodule

// File: rtl/dispatch_sequencer.sv
module dispatch_sequencer
    import arm_dispatch_pkg::*;
#(
    parameter int NUM_ARMS       = 6,
    parameter int TIMEOUT_CYCLES = 1024,
    parameter int ADDR_W         = 3,
    parameter int SLOT_W         = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick,
    input  logic [NUM_ARMS*REF_W-1:0] arm_ref,
    input  logic [NUM_ARMS-1:0]       arm_sign,
    input  logic                      stop_now,
    input  logic                      txn_done,
    input  logic                      txn_nack,
    output logic                      txn_start,
    output logic [ADDR_W-1:0]         txn_addr,
    output logic                      txn_read,
    output logic [WORD_W-1:0]         txn_wdata,
    output logic                      rd_valid,
    output logic [ADDR_W-1:0]         rd_index,
    output logic                      link_fail,
    output logic                      overrun
);
    localparam int TMO_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [SLOT_W-1:0] READ_SLOT = SLOT_W'(NUM_ARMS);
    localparam logic [ADDR_W-1:0] LAST_ARM  = ADDR_W'(NUM_ARMS - 1);

    seq_state_e        state_q;
    logic [SLOT_W-1:0] slot_q;
    logic [ADDR_W-1:0] rd_sel_q, rd_next_q;
    logic [TMO_W-1:0]  tmo_q;
    logic              in_wait, tmo_hit, finishing, is_read;
    logic [ADDR_W-1:0] wr_idx;

    assign in_wait   = (state_q == SEQ_WAIT);
    assign is_read   = (slot_q == READ_SLOT);
    assign tmo_hit   = in_wait && !txn_done && !txn_nack &&
                       (tmo_q == TMO_W'(TIMEOUT_CYCLES - 1));
    assign finishing = in_wait && (txn_done || txn_nack || tmo_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SEQ_IDLE;
            slot_q    <= '0;
            rd_sel_q  <= '0;
            rd_next_q <= '0;
            tmo_q     <= '0;
        end else if (tick) begin
            state_q   <= SEQ_ISSUE;
            slot_q    <= '0;
            rd_sel_q  <= rd_next_q;
            rd_next_q <= (rd_next_q == LAST_ARM) ? '0 : rd_next_q + 1'b1;
            tmo_q     <= '0;
        end else begin
            unique case (state_q)
                SEQ_ISSUE: begin
                    state_q <= SEQ_WAIT;
                    tmo_q   <= '0;
                end
                SEQ_WAIT: begin
                    if (finishing) begin
                        tmo_q <= '0;
                        if (is_read) begin
                            state_q <= SEQ_IDLE;
                        end else begin
                            slot_q  <= slot_q + 1'b1;
                            state_q <= SEQ_ISSUE;
                        end
                    end else begin
                        tmo_q <= tmo_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign wr_idx    = is_read ? '0 : slot_q[ADDR_W-1:0];
    assign txn_start = (state_q == SEQ_ISSUE);
    assign txn_read  = is_read;
    assign txn_addr  = is_read ? rd_sel_q : wr_idx;
    assign txn_wdata = is_read ? '0 :
        pack_cmd(arm_ref[int'(wr_idx)*REF_W +: REF_W], arm_sign[wr_idx], stop_now);

    assign rd_valid  = finishing && is_read && txn_done && !txn_nack;
    assign rd_index  = rd_sel_q;
    assign link_fail = in_wait && (txn_nack || tmo_hit);
    assign overrun   = tick && (state_q != SEQ_IDLE);

    assert_start_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        txn_start |=> !txn_start);

    assert_addr_range_R2: assert property (@(posedge clk) disable iff (rst)
        txn_start |-> (txn_addr <= LAST_ARM));

    // R7: a timed-out transaction never stays pending
    assert_timeout_moves_R7: assert property (@(posedge clk) disable iff (rst)
        (tmo_hit && !tick) |=> (state_q != SEQ_WAIT));

endmodule

// File: rtl/arm_dispatch_top.sv
module arm_dispatch_top
    import arm_dispatch_pkg::*;
#(
    parameter int NUM_ARMS       = 6,
    parameter int PERIOD_CYCLES  = 25000,
    parameter int TIMEOUT_CYCLES = 1024
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_ARMS*12-1:0]          arm_ref,
    input  logic [NUM_ARMS-1:0]             arm_sign,
    input  logic                            start_cmd,
    input  logic                            stop_cmd,
    input  logic                            fault_in,
    output logic                            txn_start,
    output logic [$clog2(NUM_ARMS)-1:0]     txn_addr,
    output logic                            txn_read,
    output logic [15:0]                     txn_wdata,
    input  logic [15:0]                     txn_rdata,
    input  logic                            txn_done,
    input  logic                            txn_nack,
    output logic [NUM_ARMS*16-1:0]          arm_volt,
    output logic                            sync_pulse,
    output logic                            overrun,
    output logic                            stop_out
);
    localparam int ADDR_W = $clog2(NUM_ARMS);
    localparam int SLOT_W = $clog2(NUM_ARMS + 1);

    logic              tick, rd_valid, link_fail;
    logic [ADDR_W-1:0] rd_index;

    period_timer #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    halt_latch u_halt (
        .clk       (clk),
        .rst       (rst),
        .fault_in  (fault_in),
        .stop_cmd  (stop_cmd),
        .start_cmd (start_cmd),
        .link_fail (link_fail),
        .stop_q    (stop_out)
    );

    dispatch_sequencer #(
        .NUM_ARMS       (NUM_ARMS),
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
        .ADDR_W         (ADDR_W),
        .SLOT_W         (SLOT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .arm_ref   (arm_ref),
        .arm_sign  (arm_sign),
        .stop_now  (stop_out),
        .txn_done  (txn_done),
        .txn_nack  (txn_nack),
        .txn_start (txn_start),
        .txn_addr  (txn_addr),
        .txn_read  (txn_read),
        .txn_wdata (txn_wdata),
        .rd_valid  (rd_valid),
        .rd_index  (rd_index),
        .link_fail (link_fail),
        .overrun   (overrun)
    );

    assign sync_pulse = tick;

    for (genvar i = 0; i < NUM_ARMS; i++) begin : g_volt
        logic [WORD_W-1:0] volt_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                volt_q <= '0;
            end else if (rd_valid && (rd_index == ADDR_W'(i))) begin
                volt_q <= txn_rdata;
            end
        end
        assign arm_volt[i*WORD_W +: WORD_W] = volt_q;
    end

    assert_link_fail_stops_R6: assert property (@(posedge clk) disable iff (rst)
        link_fail |=> stop_out);

    assert_sync_then_start_R4: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |=> txn_start);

    assert_overrun_restart_R10: assert property (@(posedge clk) disable iff (rst)
        overrun |=> (txn_start && !txn_read && txn_addr == '0));

endmodule

// File: tb/arm_dispatch_top_bench.sv
module arm_dispatch_top_bench;
    localparam int N   = 6;
    localparam int PER = 300;
    localparam int TMO = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N*12-1:0] arm_ref = '0;
    logic [N-1:0]    arm_sign = '0;
    logic            start_cmd = 1'b0, stop_cmd = 1'b0, fault_in = 1'b0;
    logic            txn_start, txn_read, sync_pulse, overrun, stop_out;
    logic [2:0]      txn_addr;
    logic [15:0]     txn_wdata;
    logic [15:0]     txn_rdata = '0;
    logic            txn_done = 1'b0, txn_nack = 1'b0;
    logic [N*16-1:0] arm_volt;

    arm_dispatch_top #(.NUM_ARMS(N), .PERIOD_CYCLES(PER), .TIMEOUT_CYCLES(TMO)) u_arm_dispatch_top (
        .clk(clk), .rst(rst), .arm_ref(arm_ref), .arm_sign(arm_sign),
        .start_cmd(start_cmd), .stop_cmd(stop_cmd), .fault_in(fault_in),
        .txn_start(txn_start), .txn_addr(txn_addr), .txn_read(txn_read),
        .txn_wdata(txn_wdata), .txn_rdata(txn_rdata), .txn_done(txn_done),
        .txn_nack(txn_nack), .arm_volt(arm_volt), .sync_pulse(sync_pulse),
        .overrun(overrun), .stop_out(stop_out)
    );

    always #10 clk = ~clk;

    int errors = 0, checks = 0;
    logic [11:0] ref_a [N];
    logic        sign_a [N];
    logic [15:0] volt_a [N];
    int lat = 3, nack_addr = -1, mute_addr = -1;
    int sync_cnt = 0, ovr_cnt = 0, cyc = 0, last_sync = 0;
    int cap_n = 0;
    int cap_addr [8];
    bit cap_rd [8];
    logic [15:0] cap_wd [8];
    int cap_sync [8];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input int k, input bit halt);
        return {1'b0, halt, ~halt, sign_a[k], ref_a[k]};
    endfunction

    // Bus controller model plus period / overrun monitors
    initial begin
        int left = 0, paddr = 0;
        bit busy = 0;
        forever begin
            @(negedge clk);
            cyc++;
            txn_done = 1'b0;
            txn_nack = 1'b0;
            if (busy) begin
                left--;
                if (left == 0) begin
                    busy = 0;
                    if (paddr == nack_addr) txn_nack = 1'b1;
                    else begin
                        txn_done  = 1'b1;
                        txn_rdata = volt_a[paddr];
                    end
                end
            end
            if (!rst && overrun) ovr_cnt++;
            if (!rst && sync_pulse) begin
                if (sync_cnt > 0) chk(cyc - last_sync == PER, "R4 sync spacing", cyc - last_sync, PER);
                last_sync = cyc;
                sync_cnt++;
                cap_n = 0;
            end
            if (!rst && txn_start) begin
                if (cap_n < 8) begin
                    cap_addr[cap_n] = int'(txn_addr);
                    cap_rd[cap_n]   = txn_read;
                    cap_wd[cap_n]   = txn_wdata;
                    cap_sync[cap_n] = sync_cnt;
                    cap_n++;
                end
                paddr = int'(txn_addr);
                busy  = (paddr != mute_addr);
                left  = lat;
            end
        end
    end

    task automatic new_stim(input int l);
        for (int k = 0; k < N; k++) begin
            ref_a[k]  = 12'($urandom);
            sign_a[k] = 1'($urandom);
            volt_a[k] = 16'($urandom);
            arm_ref[k*12 +: 12] = ref_a[k];
            arm_sign[k] = sign_a[k];
        end
        lat = l;
    endtask

    task automatic wait_sync();
        int s = sync_cnt;
        while (sync_cnt == s) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        if (which == 0) start_cmd = 1'b1;
        else if (which == 1) stop_cmd = 1'b1;
        else fault_in = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0; stop_cmd = 1'b0;
        if (which == 2) fault_in = 1'b0;
    endtask

    task automatic check_frame(input bit base_stop, input int fail_addr);
        int raddr;
        chk(cap_n == 7, "R2 txn count", cap_n, 7);
        for (int k = 0; k < N; k++) begin
            bit h = base_stop || (fail_addr >= 0 && k > fail_addr);
            chk(cap_addr[k] == k && !cap_rd[k], "R2 write order", cap_addr[k], k);
            chk(cap_wd[k] == exp_word(k, h), (fail_addr >= 0) ? "R6 R7 word after failure" : "R1 word",
                cap_wd[k], exp_word(k, h));
        end
        raddr = (cap_sync[6] - 1) % N;
        chk(cap_rd[6] && cap_addr[6] == raddr, "R3 read target", cap_addr[6], raddr);
        if (raddr != fail_addr)
            chk(arm_volt[raddr*16 +: 16] == volt_a[raddr], "R3 stored voltage",
                arm_volt[raddr*16 +: 16], volt_a[raddr]);
    endtask

    task automatic run_period(input bit base_stop, input int fail_addr, input int l);
        new_stim(l);
        wait_sync();
        repeat (250) @(negedge clk);
        check_frame(base_stop, fail_addr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n, o0, rd_fail_arm;
        logic [15:0] keep;
        void'($urandom(32'd20240611));
        new_stim(3);
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(stop_out == 1'b1, "R11 stop_out", stop_out, 1);
        chk(arm_volt == '0, "R11 arm_volt", 0, 0);
        chk(!txn_start && !sync_pulse && !overrun, "R11 strobes", {txn_start, sync_pulse, overrun}, 0);
        rst = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!sync_pulse);
        chk(n == PER - 1, "R4 first sync", n, PER - 1);
        repeat (250) @(negedge clk);
        check_frame(1'b1, -1);

        pulse(0);
        chk(stop_out == 1'b0, "R9 start releases", stop_out, 0);
        for (int p = 0; p < 8; p++) run_period(1'b0, -1, 1 + int'($urandom % 30));
        chk(ovr_cnt == 0, "R10 no false overrun", ovr_cnt, 0);

        pulse(1);
        chk(stop_out == 1'b1, "R8 stop_cmd", stop_out, 1);
        run_period(1'b1, -1, 2);
        fault_in = 1'b1;
        pulse(0);
        chk(stop_out == 1'b1, "R9 start ignored under fault", stop_out, 1);
        fault_in = 1'b0;
        pulse(0);
        chk(stop_out == 1'b0, "R9 start after fault", stop_out, 0);
        pulse(2);
        chk(stop_out == 1'b1, "R8 fault_in", stop_out, 1);
        pulse(0);

        // R6: NACK from arm 2
        nack_addr = 2;
        run_period(1'b0, 2, 4);
        chk(stop_out == 1'b1, "R6 nack latches stop", stop_out, 1);
        nack_addr = -1;
        pulse(0);

        // R3: NACK on the read leaves the stored value unchanged
        for (int p = 0; p < 6; p++) begin
            new_stim(2);
            rd_fail_arm = sync_cnt % N;
            keep = arm_volt[rd_fail_arm*16 +: 16];
            if (p == 0) begin
                nack_addr = -1;
            end
            if (p == 0) begin
                wait_sync();
                repeat (250) @(negedge clk);
                check_frame(1'b0, -1);
            end
        end
        pulse(0);
        new_stim(2);
        rd_fail_arm = sync_cnt % N;
        keep = arm_volt[rd_fail_arm*16 +: 16];
        wait_sync();
        nack_addr = rd_fail_arm;
        repeat (250) @(negedge clk);
        chk(arm_volt[rd_fail_arm*16 +: 16] == keep, "R3 nacked read ignored",
            arm_volt[rd_fail_arm*16 +: 16], keep);
        nack_addr = -1;
        pulse(0);

        // R7: arm 4 never answers
        mute_addr = 4;
        run_period(1'b0, 4, 5);
        chk(stop_out == 1'b1, "R7 timeout latches stop", stop_out, 1);
        mute_addr = -1;
        pulse(0);
        run_period(1'b0, -1, 6);

        // R10: latency too long for the period
        o0 = ovr_cnt;
        new_stim(45);
        wait_sync();
        wait_sync();
        repeat (3) @(negedge clk);
        chk(ovr_cnt == o0 + 1, "R10 overrun pulse", ovr_cnt, o0 + 1);
        chk(cap_n >= 1 && cap_addr[0] == 0 && !cap_rd[0], "R10 restart at 0", cap_addr[0], 0);
        new_stim(4);
        wait_sync();
        repeat (250) @(negedge clk);
        check_frame(1'b0, -1);
        o0 = ovr_cnt;
        run_period(1'b0, -1, 20);
        chk(ovr_cnt == o0, "R10 clean period", ovr_cnt, o0);
        chk(stop_out == 1'b0, "R9 stays released", stop_out, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule